// File: doc/BRIEF.md
# Winograd 2x2 Output Tile Engine for 3x3 Convolution

The engine produces a 2x2 block of a 3x3 convolution (correlation form, no kernel flip) from a 4x4 window of input data. It uses the minimal-filtering scheme built by nesting the one-dimensional two-output, three-tap form. Each accepted beat carries one 4x4 data tile for one input channel together with a 4x4 tile of weights that are already in the transform domain. The engine moves the data tile into the transform domain and multiplies the two tiles element by element. It adds the sixteen products into per-element running sums across channels. When a beat marked as the last channel of a group has been taken in, the engine maps the sums back through the output transform and emits the 2x2 result.

Work per tile is sixteen multiplies, where a direct 3x3 computation of four outputs needs thirty-six. A caller streams the channels of one output tile back to back and flags the final one. Groups may follow each other with no gap. All arithmetic is signed two's-complement integer. The internal widths grow far enough that the maximum group length cannot overflow.

Top module: `wino_tile_engine`

## Requirements
- R1: While rst_n is low, out_valid and in_ready are 0. From the first rising edge with rst_n high, in_ready is 1. A beat is accepted on a rising edge where in_valid and in_ready are both 1.
- R2: The data tile d, with element (i,j) at in_data[(4i+j)*8 +: 8], is transformed along columns and then along rows by the 1D rule v0=x0-x2, v1=x1+x2, v2=x2-x1, v3=x1-x3. An all-zero data tile therefore adds nothing to any sum.
- R3: Within a group, each transform-domain data element is multiplied by the weight element at the same index. The weight element (i,j) sits at in_weight[(4i+j)*10 +: 10]. The products are summed over all beats of the group. The 4x4 sum M is reduced with the rule y0=x0+x1+x2, y1=x1-x2-x3, first along columns and then along rows. Output element (i,j) appears at out_data[(2i+j)*32 +: 32].
- R4: Suppose each beat's weight tile equals H·w·H^T, where w is a 3x3 kernel and H has the rows (2,0,0), (1,1,1), (1,-1,1), (0,0,2). Then out_data(i,j) equals 4·Σ over channels of Σ_{a,b} d[i+a][j+b]·w[a][b].
- R5: A beat with in_last=1 closes its group and clears the running sums. The next group's result depends only on its own beats.
- R6: A group of a single beat, with in_last=1 on its only beat, gives the result for that beat alone.
- R7: For every accepted beat with in_last=1, out_valid is 1 for exactly one cycle, two rising edges after the accepting edge. Accepted beats with in_last=0 produce no output. A new beat may be accepted on every clock.
- R8: Cycles in which in_valid is 0 change no running sum, whatever in_data, in_weight and in_last carry.
- R9: Groups of 256 channels with full-range data (-128..127) and weights (|value| up to 504) give exact results with no overflow.
- R10: The weight tile is taken with each beat, so it may differ from one beat to the next within a group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Beat present on the inputs |
| in_ready | output | 1 | Engine can take a beat |
| in_last | input | 1 | Beat is the final channel of the group |
| in_data | input | 128 | 4x4 signed 8-bit data tile, row-major |
| in_weight | input | 160 | 4x4 signed 10-bit transformed weight tile, row-major |
| out_valid | output | 1 | Result tile present for one cycle |
| out_data | output | 128 | 2x2 signed 32-bit result tile, row-major |

## Verification
Random multi-channel groups are compared against a direct 3x3 correlation. This shows that the transforms and the accumulation agree with the intended arithmetic rather than with some other linear map. Single-beat groups sent back to back separate correct clearing and one-per-clock issue from results that bleed between groups. Bubbles filled with garbage, and weights that change within a group, show that only accepted beats count and that each weight travels with its own beat. A zero tile checks the input transform's null case. Long groups of full-range data and weights probe the extremes, where truncated intermediate widths would show up as wrong results.

// File: rtl/wino_pkg.sv
// Shared geometry of the F(2x2,3x3) tile engine.
// Assumes: 4x4 transform-domain tiles and 2x2 output tiles; widths are set per module.
package wino_pkg;
    localparam int NT  = 4;        // tile edge in the transform domain
    localparam int NE  = NT * NT;  // elements per transform tile
    localparam int NO  = 2;        // output tile edge
    localparam int NOE = NO * NO;  // elements per output tile
endpackage

// File: rtl/wino_in_xform.sv
// Stage 1: applies the column-then-row input transform to a 4x4 data tile and
// registers it together with the beat's weight tile and last flag.
// Assumes: signed row-major flat inputs; output width grows by two bits.
module wino_in_xform
    import wino_pkg::*;
#(
    parameter int DW = 8,
    parameter int WW = 10,
    localparam int TW = DW + 1,
    localparam int VW = DW + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire,
    input  logic               last,
    input  logic [NE*DW-1:0]   d_flat,
    input  logic [NE*WW-1:0]   w_flat,
    output logic               s1_valid,
    output logic               s1_last,
    output logic [NE*VW-1:0]   v_flat,
    output logic [NE*WW-1:0]   w_q
);
    logic signed [TW-1:0] de [NE];
    logic signed [TW-1:0] t  [NE];
    logic signed [VW-1:0] te [NE];
    logic signed [VW-1:0] v  [NE];

    for (genvar k = 0; k < NE; k++) begin : g_ext
        assign de[k] = $signed({d_flat[k*DW+DW-1], d_flat[k*DW +: DW]});
        assign te[k] = $signed({t[k][TW-1], t[k]});
    end

    // Column pass: combine rows of each column.
    for (genvar j = 0; j < NT; j++) begin : g_col
        assign t[0*NT+j] = de[0*NT+j] - de[2*NT+j];
        assign t[1*NT+j] = de[1*NT+j] + de[2*NT+j];
        assign t[2*NT+j] = de[2*NT+j] - de[1*NT+j];
        assign t[3*NT+j] = de[1*NT+j] - de[3*NT+j];
    end

    // Row pass: combine columns of each row.
    for (genvar i = 0; i < NT; i++) begin : g_row
        assign v[i*NT+0] = te[i*NT+0] - te[i*NT+2];
        assign v[i*NT+1] = te[i*NT+1] + te[i*NT+2];
        assign v[i*NT+2] = te[i*NT+2] - te[i*NT+1];
        assign v[i*NT+3] = te[i*NT+1] - te[i*NT+3];
    end

    // Register the transformed tile and its companions for the multiply stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_last  <= 1'b0;
        end else begin
            s1_valid <= fire;
            s1_last  <= fire & last;
            if (fire) begin
                for (int k = 0; k < NE; k++) v_flat[k*VW +: VW] <= v[k];
                w_q <= w_flat;
            end
        end
    end

    // R2: a zero data tile leaves a zero transformed tile.
    a_r2_zero_tile: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && d_flat == '0) |=> (v_flat == '0));
endmodule

// File: rtl/wino_mac.sv
// Stage 2: element-wise product of transformed data and weights, summed over
// the channels of a group; a last beat hands the sums on and clears them.
// Assumes: AW covers the longest group the caller sends.
module wino_mac
    import wino_pkg::*;
#(
    parameter int VW = 10,
    parameter int WW = 10,
    parameter int AW = 28,
    localparam int PW = VW + WW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               s1_valid,
    input  logic               s1_last,
    input  logic [NE*VW-1:0]   v_flat,
    input  logic [NE*WW-1:0]   w_flat,
    output logic               s2_valid,
    output logic [NE*AW-1:0]   sum_flat
);
    logic signed [PW-1:0] prod [NE];
    logic signed [AW-1:0] acc  [NE];
    logic signed [AW-1:0] nxt  [NE];
    logic                 acc_any;

    for (genvar k = 0; k < NE; k++) begin : g_mul
        logic signed [VW-1:0] vk;
        logic signed [WW-1:0] wk;
        assign vk      = $signed(v_flat[k*VW +: VW]);
        assign wk      = $signed(w_flat[k*WW +: WW]);
        assign prod[k] = vk * wk;
        assign nxt[k]  = acc[k] + $signed({{(AW-PW){prod[k][PW-1]}}, prod[k]});
    end

    // Flag any nonzero running sum, used by the clearing check.
    always_comb begin
        acc_any = 1'b0;
        for (int k = 0; k < NE; k++) acc_any = acc_any | (|acc[k]);
    end

    // Accumulate per element; on the last beat, publish and restart from zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            for (int k = 0; k < NE; k++) acc[k] <= '0;
        end else begin
            s2_valid <= s1_valid & s1_last;
            if (s1_valid) begin
                for (int k = 0; k < NE; k++) begin
                    if (s1_last) begin
                        sum_flat[k*AW +: AW] <= nxt[k];
                        acc[k]               <= '0;
                    end else begin
                        acc[k] <= nxt[k];
                    end
                end
            end
        end
    end

    // R5: sums are empty right after a group closes.
    a_r5_acc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_last) |=> !acc_any);
    // R7: a sum tile is published only for a closing beat.
    a_r7_sum_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        s2_valid |-> $past(s1_valid && s1_last));
endmodule

// File: rtl/wino_out_xform.sv
// Stage 3: reduces the 4x4 channel sums to the 2x2 result, column pass then
// row pass, and registers it with a one-cycle valid.
// Assumes: each 3-term pass may add two bits, so the result is AW+4 wide.
module wino_out_xform
    import wino_pkg::*;
#(
    parameter int AW = 28,
    localparam int SW = AW + 2,
    localparam int YW = AW + 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               s2_valid,
    input  logic [NE*AW-1:0]   sum_flat,
    output logic               out_valid,
    output logic [NOE*YW-1:0]  out_flat
);
    logic signed [SW-1:0] me [NE];
    logic signed [SW-1:0] s  [NO*NT];
    logic signed [YW-1:0] se [NO*NT];
    logic signed [YW-1:0] y  [NOE];

    for (genvar k = 0; k < NE; k++) begin : g_ext
        assign me[k] = $signed({{2{sum_flat[k*AW+AW-1]}}, sum_flat[k*AW +: AW]});
    end

    // Column pass: two output rows from four sum rows.
    for (genvar j = 0; j < NT; j++) begin : g_col
        assign s[0*NT+j] = me[0*NT+j] + me[1*NT+j] + me[2*NT+j];
        assign s[1*NT+j] = me[1*NT+j] - me[2*NT+j] - me[3*NT+j];
    end

    // Row pass: two output columns from four.
    for (genvar i = 0; i < NO; i++) begin : g_row
        for (genvar j = 0; j < NT; j++) begin : g_e
            assign se[i*NT+j] = $signed({{2{s[i*NT+j][SW-1]}}, s[i*NT+j]});
        end
        assign y[i*NO+0] = se[i*NT+0] + se[i*NT+1] + se[i*NT+2];
        assign y[i*NO+1] = se[i*NT+1] - se[i*NT+2] - se[i*NT+3];
    end

    // Register the result tile and its valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= s2_valid;
            if (s2_valid) begin
                for (int k = 0; k < NOE; k++) out_flat[k*YW +: YW] <= y[k];
            end
        end
    end

    // R7: a result appears only one edge after a published sum tile.
    a_r7_out_after_sum: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(s2_valid));
    // R7: a result is a single-cycle pulse unless sums arrive back to back.
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !s2_valid) |=> !out_valid);
endmodule

// File: rtl/wino_tile_engine.sv
// Top: three-stage F(2x2,3x3) tile engine (input transform, multiply and
// channel accumulate, output transform), one beat per clock.
// Assumes: weights arrive already transformed; groups are at most MAX_CH beats.
module wino_tile_engine
    import wino_pkg::*;
#(
    parameter int DW     = 8,
    parameter int WW     = 10,
    parameter int MAX_CH = 256,
    localparam int VW = DW + 2,
    localparam int AW = VW + WW + $clog2(MAX_CH),
    localparam int OW = AW + 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               in_last,
    input  logic [NE*DW-1:0]   in_data,
    input  logic [NE*WW-1:0]   in_weight,
    output logic               out_valid,
    output logic [NOE*OW-1:0]  out_data
);
    logic               fire;
    logic               s1_valid, s1_last, s2_valid;
    logic [NE*VW-1:0]   v_flat;
    logic [NE*WW-1:0]   w_q;
    logic [NE*AW-1:0]   sum_flat;

    // Ready rises on the first edge out of reset and stays up: no stalls.
    always_ff @(posedge clk) begin
        if (!rst_n) in_ready <= 1'b0;
        else        in_ready <= 1'b1;
    end

    assign fire = in_valid & in_ready;

    wino_in_xform #(.DW(DW), .WW(WW)) u_in (
        .clk(clk), .rst_n(rst_n), .fire(fire), .last(in_last),
        .d_flat(in_data), .w_flat(in_weight),
        .s1_valid(s1_valid), .s1_last(s1_last), .v_flat(v_flat), .w_q(w_q)
    );

    wino_mac #(.VW(VW), .WW(WW), .AW(AW)) u_mac (
        .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_last(s1_last),
        .v_flat(v_flat), .w_flat(w_q), .s2_valid(s2_valid), .sum_flat(sum_flat)
    );

    wino_out_xform #(.AW(AW)) u_out (
        .clk(clk), .rst_n(rst_n), .s2_valid(s2_valid), .sum_flat(sum_flat),
        .out_valid(out_valid), .out_flat(out_data)
    );

    // R1: once out of reset, the engine keeps accepting.
    a_r1_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> in_ready);
endmodule

// File: tb/wino_tile_engine_test.sv
`timescale 1ns/1ps
module wino_tile_engine_test;
    localparam int DW = 8, WW = 10, MAX_CH = 256;
    localparam int VW = DW + 2;
    localparam int AW = VW + WW + $clog2(MAX_CH);
    localparam int OW = AW + 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0;
    logic in_ready, out_valid;
    logic [16*DW-1:0] in_data = '0;
    logic [16*WW-1:0] in_weight = '0;
    logic [4*OW-1:0]  out_data;

    always #4 clk = ~clk;

    wino_tile_engine uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_last(in_last), .in_data(in_data), .in_weight(in_weight),
        .out_valid(out_valid), .out_data(out_data)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;
    logic [4*OW-1:0] exp_q[$];
    int              due_q[$];
    string           tag_q[$];
    int     wk[3][3];
    longint accx[4];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input bit ok, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, expv);
        end
    endtask

    // New 3x3 kernel; big=1 uses +/-56 for full-range weights.
    task automatic new_kernel(input bit big);
        for (int a = 0; a < 3; a++)
            for (int b = 0; b < 3; b++)
                wk[a][b] = big ? ($urandom_range(0, 1) ? 56 : -56) : $urandom_range(0, 40) - 20;
    endtask

    // One beat: dmode 0 random, 1 full-range extremes, 2 zeros. Caller sits at a negedge.
    task automatic send_beat(input bit last, input int dmode, input int gap, input string tag);
        int d[4][4];
        int hm[4][3] = '{'{2,0,0}, '{1,1,1}, '{1,-1,1}, '{0,0,2}};
        int tmp[4][3];
        int u;
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++) begin
                case (dmode)
                    0: d[i][j] = $urandom_range(0, 255) - 128;
                    1: d[i][j] = $urandom_range(0, 1) ? 127 : -128;
                    default: d[i][j] = 0;
                endcase
                in_data[(4*i+j)*DW +: DW] = DW'(d[i][j]);
            end
        for (int i = 0; i < 4; i++)
            for (int b = 0; b < 3; b++) begin
                tmp[i][b] = 0;
                for (int a = 0; a < 3; a++) tmp[i][b] += hm[i][a] * wk[a][b];
            end
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++) begin
                u = 0;
                for (int b = 0; b < 3; b++) u += tmp[i][b] * hm[j][b];
                in_weight[(4*i+j)*WW +: WW] = WW'(u);
            end
        for (int i = 0; i < 2; i++)
            for (int j = 0; j < 2; j++)
                for (int a = 0; a < 3; a++)
                    for (int b = 0; b < 3; b++)
                        accx[2*i+j] += 4 * longint'(d[i+a][j+b]) * longint'(wk[a][b]);
        in_valid = 1'b1;
        in_last  = last;
        @(negedge clk);
        in_valid = 1'b0;
        if (last) begin
            logic [4*OW-1:0] e;
            for (int k = 0; k < 4; k++) begin
                e[k*OW +: OW] = OW'(accx[k]);
                accx[k] = 0;
            end
            exp_q.push_back(e);
            due_q.push_back(cyc + 2);
            tag_q.push_back(tag);
        end
        // R8: bubbles carry garbage that must not count.
        for (int g = 0; g < gap; g++) begin
            in_data   = {4{$urandom()}};
            in_weight = {5{$urandom()}};
            in_last   = $urandom_range(0, 1);
            @(negedge clk);
        end
    endtask

    task automatic send_group(input int nch, input int dmode, input bit big,
                              input bit wchg, input int gap, input string tag);
        new_kernel(big);
        for (int c = 0; c < nch; c++) begin
            if (wchg && c > 0) new_kernel(big);
            send_beat(c == nch - 1, dmode, gap, tag);
        end
    endtask

    // Scoreboard monitor: pops the oldest expected tile per result.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R7 unexpected output", 1'b0, 1, 0);
            end else begin
                logic [4*OW-1:0] e;
                int due;
                string t;
                e = exp_q.pop_front();
                due = due_q.pop_front();
                t = tag_q.pop_front();
                for (int k = 0; k < 4; k++)
                    check(t, out_data[k*OW +: OW] == e[k*OW +: OW],
                          longint'($signed(out_data[k*OW +: OW])), longint'($signed(e[k*OW +: OW])));
                check("R7 latency", cyc == due, cyc, due);
            end
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) accx[k] = 0;
        // R1: reset state.
        repeat (3) begin
            @(negedge clk);
            check("R1 out_valid in reset", out_valid == 1'b0, out_valid, 0);
            check("R1 in_ready in reset", in_ready == 1'b0, in_ready, 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 in_ready after reset", in_ready == 1'b1, in_ready, 1);

        // R3 R4 R5: random multi-channel groups back to back.
        send_group(4, 0, 0, 0, 0, "R4 random 4ch");
        send_group(8, 0, 0, 0, 0, "R3 random 8ch");
        send_group(3, 0, 0, 0, 0, "R5 group after group");
        // R6 R7: single-beat groups every clock.
        for (int n = 0; n < 6; n++) send_group(1, 0, 0, 0, 0, "R6 single beat");
        // R8: bubbles with garbage between beats.
        send_group(5, 0, 0, 0, 2, "R8 bubbles");
        // R10: kernel changes each beat.
        send_group(6, 0, 0, 1, 0, "R10 per-beat weights");
        // R2: zero data tiles give zero result.
        send_group(3, 2, 1, 0, 0, "R2 zero tile");
        // R2: zero tile mixed into a group adds nothing.
        new_kernel(0);
        send_beat(0, 0, 0, "R2 zero in group");
        send_beat(0, 2, 0, "R2 zero in group");
        send_beat(1, 0, 0, "R2 zero in group");
        // R9: full-range 256-channel groups.
        send_group(256, 1, 1, 0, 0, "R9 extremes 256ch");
        send_group(256, 1, 1, 1, 0, "R9 extremes varying");
        send_group(2, 0, 0, 0, 0, "R5 after long group");

        repeat (10) @(negedge clk);
        check("R7 all results seen", exp_q.size() == 0, exp_q.size(), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule